// File: doc/BRIEF.md
# Interrupt Priority and Delivery Arbiter

This block sits between the interrupt message receiver and a processor core. Each request arrives as a single-cycle strobe with an 8-bit vector, a 3-bit delivery mode and a level/edge flag. Ordinary requests (fixed or lowest-priority mode) are queued as one bit per vector in a 256-entry request array, and a parallel 256-entry trigger array records level or edge. Four special modes bypass that array. Each of them is held in a pending latch of its own together with its vector. Three of them (system management, non-maskable and init) also raise a shared unmaskable flag.

Every cycle the arbiter chooses one presented source. The choices are the classes SRC_NONE, SRC_SMI, SRC_NMI, SRC_INIT, SRC_EXT and SRC_FIXED. The choice depends on the pending latches, the core's interrupt-enable input, the task-priority input and the highest vectors in the request and in-service arrays. An acknowledge from the core moves the presented source to service. For SRC_SMI, SRC_NMI, SRC_INIT and SRC_EXT this clears that source's latch. For SRC_FIXED the request bit moves to the in-service array. An end-of-interrupt retires the highest in-service vector, which can uncover a lower queued vector.

Top module: `irq_arbiter`

## Requirements
- R1: Modes 0 (fixed) and 1 (lowest-priority) set the vector's request bit only when it is clear. Only that first setting writes the trigger bit, to 1 for level and 0 for edge. The trigger bit of the presented vector appears on irq_level.
- R2: Mode 2 (SMI), 4 (NMI), 5 (INIT) and 7 (ExtInt) each latch their vector only when that source is not already pending. A repeat request while pending changes neither the flag nor the vector.
- R3: Requests with mode 3 or 6 change no state.
- R4: Whenever SMI, NMI or INIT is pending, irq_pending is 1 whatever the value of irq_en.
- R5: A pending ExtInt is presented only while irq_en is 1.
- R6: A queued vector is presented only when all of the following hold: irq_en is 1, the highest requested vector is strictly greater than the highest in-service vector (taken as 0 when none), and its bits 7:4 are strictly greater than task_prio bits 7:4.
- R7: The presentation order is SMI, then NMI, then INIT, then ExtInt, then the highest queued vector. irq_src codes are 0 none, 1 SMI, 2 NMI, 3 INIT, 4 ExtInt, 5 queued. irq_vector carries the presented vector, and is 0 when nothing is presented.
- R8: An acknowledge clears only the presented source. An acknowledge while nothing is presented has no effect.
- R9: The unmaskable flag stays set while any of SMI, NMI or INIT remains pending, and drops only when none of them is pending.
- R10: Acknowledging a queued vector sets its in-service bit and clears its request bit. The next highest request then becomes the candidate.
- R11: End-of-interrupt clears the highest set in-service bit. With none set it does nothing.
- R12: After reset nothing is pending: irq_pending 0, irq_src 0, irq_vector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_mode | input | 3 | Delivery mode of the request |
| req_vector | input | 8 | Vector of the request |
| req_level | input | 1 | 1 for level-triggered, 0 for edge |
| task_prio | input | 8 | Task priority; bits 7:4 gate queued vectors |
| irq_en | input | 1 | Core interrupt enable |
| ack | input | 1 | Core takes the presented interrupt |
| eoi | input | 1 | End of interrupt for the highest in-service vector |
| irq_pending | output | 1 | An interrupt is presented to the core |
| irq_src | output | 3 | Class of the presented interrupt |
| irq_vector | output | 8 | Vector of the presented interrupt |
| irq_level | output | 1 | Trigger bit of a presented queued vector |

## Verification
The bench repeats a queued vector with the opposite trigger flag. A design that rewrote the trigger bit on a duplicate would then report the wrong level. It places task priority exactly on the vector's class and re-requests a vector equal to the one in service. A design using >= instead of > would present an interrupt in either case. It stacks INIT, NMI and SMI with interrupts disabled and acknowledges them one at a time. A design that dropped the unmaskable flag early, or cleared more than one latch, would lose irq_pending or skip a source. It also acknowledges while nothing is presented but a masked request waits behind a higher in-service vector. A design that serviced the queue anyway would hide that vector after the following end-of-interrupt.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_RSV6   = 3'd6,
        DM_EXTINT = 3'd7
    } dmode_e;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_SMI   = 3'd1,
        SRC_NMI   = 3'd2,
        SRC_INIT  = 3'd3,
        SRC_EXT   = 3'd4,
        SRC_FIXED = 3'd5
    } src_e;

    // Special sources, index order is also presentation order.
    localparam int NSPC = 4;
    localparam int NUNM = 3;

    function automatic dmode_e spc_mode(input int idx);
        case (idx)
            0:       return DM_SMI;
            1:       return DM_NMI;
            2:       return DM_INIT;
            default: return DM_EXTINT;
        endcase
    endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N = 256,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] bits_i,
    output logic [W-1:0] idx_o,
    output logic         any_o
);
    // Highest set bit wins; no bit set reports index 0 with any_o low.
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (bits_i[i]) begin
                idx_o = W'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_spc_latch.sv
module irq_spc_latch
    import irq_arb_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_mode,
    input  logic [VW-1:0]            req_vector,
    input  logic                     take,
    input  logic [1:0]               take_idx,
    output logic [NSPC-1:0]          pend_o,
    output logic [NSPC-1:0][VW-1:0]  vec_o,
    output logic                     unm_o
);
    logic [NSPC-1:0] set_now;
    logic [NSPC-1:0] clr_now;

    for (genvar g = 0; g < NSPC; g++) begin : g_src
        assign clr_now[g] = take && (take_idx == 2'(g));
        assign set_now[g] = req_valid && (req_mode == spc_mode(g))
                            && !pend_o[g] && !clr_now[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_o[g] <= 1'b0;
                vec_o[g]  <= '0;
            end else if (clr_now[g]) begin
                pend_o[g] <= 1'b0;
            end else if (set_now[g]) begin
                pend_o[g] <= 1'b1;
                vec_o[g]  <= req_vector;
            end
        end
    end

    logic [NUNM-1:0] unm_left;
    logic            unm_taken;
    assign unm_left  = pend_o[NUNM-1:0] & ~clr_now[NUNM-1:0];
    assign unm_taken = |clr_now[NUNM-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unm_o <= 1'b0;
        end else if (|set_now[NUNM-1:0]) begin
            unm_o <= 1'b1;
        end else if (unm_taken && !(|unm_left)) begin
            unm_o <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int VW    = 8,
    parameter int CLS_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_mode,
    input  logic [VW-1:0] req_vector,
    input  logic          req_level,
    input  logic [VW-1:0] task_prio,
    input  logic          irq_en,
    input  logic          ack,
    input  logic          eoi,
    output logic          irq_pending,
    output logic [2:0]    irq_src,
    output logic [VW-1:0] irq_vector,
    output logic          irq_level
);
    localparam int NV = 1 << VW;

    logic [NV-1:0] irr, tmr, isr;
    logic [VW-1:0] irrv, isrv;
    logic          irr_any, isr_any;

    irq_prio_enc #(.N(NV), .W(VW)) u_irr_enc (.bits_i(irr), .idx_o(irrv), .any_o(irr_any));
    irq_prio_enc #(.N(NV), .W(VW)) u_isr_enc (.bits_i(isr), .idx_o(isrv), .any_o(isr_any));

    logic [NSPC-1:0]         spc_pend;
    logic [NSPC-1:0][VW-1:0] spc_vec;
    logic                    unm_pend;
    logic                    take;
    logic [1:0]              take_idx;

    irq_spc_latch #(.VW(VW)) u_spc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_vector(req_vector), .take(take), .take_idx(take_idx),
        .pend_o(spc_pend), .vec_o(spc_vec), .unm_o(unm_pend)
    );

    // Presented source selection.
    src_e sel;
    logic fix_ok;
    assign fix_ok = irr_any && (irrv > isrv)
                    && (irrv[VW-1 -: CLS_W] > task_prio[VW-1 -: CLS_W]);

    always_comb begin
        if (spc_pend[0])                  sel = SRC_SMI;
        else if (spc_pend[1])             sel = SRC_NMI;
        else if (spc_pend[2])             sel = SRC_INIT;
        else if (irq_en && spc_pend[3])   sel = SRC_EXT;
        else if (irq_en && fix_ok)        sel = SRC_FIXED;
        else                              sel = SRC_NONE;
    end

    // Outputs and service routing per presented source.
    always_comb begin
        irq_vector = '0;
        irq_level  = 1'b0;
        take       = 1'b0;
        take_idx   = 2'd0;
        unique case (sel)
            SRC_SMI:   begin irq_vector = spc_vec[0]; take = ack; take_idx = 2'd0; end
            SRC_NMI:   begin irq_vector = spc_vec[1]; take = ack; take_idx = 2'd1; end
            SRC_INIT:  begin irq_vector = spc_vec[2]; take = ack; take_idx = 2'd2; end
            SRC_EXT:   begin irq_vector = spc_vec[3]; take = ack; take_idx = 2'd3; end
            SRC_FIXED: begin irq_vector = irrv; irq_level = tmr[irrv]; end
            SRC_NONE:  begin end
            default:   begin end
        endcase
    end

    assign irq_pending = (sel != SRC_NONE);
    assign irq_src     = sel;

    logic q_req, grant_fix;
    assign q_req     = req_valid && ((dmode_e'(req_mode) == DM_FIXED) ||
                                     (dmode_e'(req_mode) == DM_LOWEST));
    assign grant_fix = ack && (sel == SRC_FIXED);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
            tmr <= '0;
            isr <= '0;
        end else begin
            if (q_req && !irr[req_vector]) begin
                irr[req_vector] <= 1'b1;
                tmr[req_vector] <= req_level;
            end
            if (eoi && isr_any) isr[isrv] <= 1'b0;
            if (grant_fix) begin
                irr[irrv] <= 1'b0;
                isr[irrv] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter int VW = 8,
    parameter int NV = 1 << VW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      req_mode,
    input logic            irq_en,
    input logic            ack,
    input logic            irq_pending,
    input logic [2:0]      irq_src,
    input logic [VW-1:0]   irq_vector,
    input logic [NSPC-1:0] spc_pend,
    input logic            unm_pend,
    input logic [NV-1:0]   irr,
    input logic [NV-1:0]   isr
);
    // R9
    unm_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unm_pend == (|spc_pend[NUNM-1:0]));

    // R4
    masked_only_unm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !irq_en) |-> unm_pend);

    // R7
    smi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spc_pend[0] |-> (irq_src == 3'd1));

    // R8
    nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_src == 3'd2) |=> !spc_pend[1]);

    // R10
    fix_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_src == 3'd5) |=> (isr[$past(irq_vector)] && !irr[$past(irq_vector)]));

    // R3
    rsv_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_mode == 3'd3 || req_mode == 3'd6) && !ack)
        |=> ($stable(irr) && $stable(spc_pend)));
endmodule

bind irq_arbiter irq_arbiter_chk #(.VW(VW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .irq_en(irq_en), .ack(ack), .irq_pending(irq_pending), .irq_src(irq_src),
    .irq_vector(irq_vector), .spc_pend(spc_pend), .unm_pend(unm_pend),
    .irr(irr), .isr(isr)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_mode = '0;
    logic [7:0] req_vector = '0;
    logic       req_level = 1'b0;
    logic [7:0] task_prio = '0;
    logic       irq_en = 1'b0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       irq_pending;
    logic [2:0] irq_src;
    logic [7:0] irq_vector;
    logic       irq_level;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    irq_arbiter i_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_vector(req_vector), .req_level(req_level), .task_prio(task_prio),
        .irq_en(irq_en), .ack(ack), .eoi(eoi), .irq_pending(irq_pending),
        .irq_src(irq_src), .irq_vector(irq_vector), .irq_level(irq_level)
    );

    task automatic chk(input string rid, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", rid, act, exp);
        end
    endtask

    task automatic pres(input string rid, input logic p, input logic [2:0] s, input logic [7:0] v);
        chk({rid, " pending"}, irq_pending, p);
        chk({rid, " src"}, irq_src, s);
        chk({rid, " vector"}, irq_vector, v);
    endtask

    task automatic send(input logic [2:0] m, input logic [7:0] v, input logic lvl);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_vector = v; req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        #1;
    endtask

    task automatic do_eoi();
        @(negedge clk); eoi = 1'b1;
        @(negedge clk); eoi = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        pres("R12 reset", 1'b0, 3'd0, 8'h00);
    endtask

    task automatic t_queue();
        irq_en = 1'b1;
        send(3'd0, 8'h45, 1'b0);
        pres("R1 fixed queued", 1'b1, 3'd5, 8'h45);
        chk("R1 edge trigger", irq_level, 1'b0);
        send(3'd0, 8'h45, 1'b1);
        chk("R1 duplicate keeps trigger", irq_level, 1'b0);
        send(3'd1, 8'h80, 1'b1);
        pres("R1 lowest-priority queued", 1'b1, 3'd5, 8'h80);
        chk("R1 level trigger", irq_level, 1'b1);
    endtask

    task automatic t_gate();
        task_prio = 8'h80; #1;
        chk("R6 class equal to task priority blocks", irq_pending, 1'b0);
        task_prio = 8'h7F; #1;
        pres("R6 class above task priority", 1'b1, 3'd5, 8'h80);
        task_prio = 8'h00;
        irq_en = 1'b0; #1;
        chk("R6 disabled blocks queued", irq_pending, 1'b0);
        irq_en = 1'b1; #1;
    endtask

    task automatic t_service();
        do_ack();
        chk("R10 lower request behind in-service", irq_pending, 1'b0);
        do_ack();
        do_eoi();
        pres("R8 idle ack ignored, R11 eoi uncovers", 1'b1, 3'd5, 8'h45);
        do_ack();
        chk("R10 serviced request cleared", irq_pending, 1'b0);
        send(3'd0, 8'h45, 1'b0);
        chk("R6 equal to in-service blocks", irq_pending, 1'b0);
        do_eoi();
        pres("R11 eoi retires in-service", 1'b1, 3'd5, 8'h45);
        do_ack();
        do_eoi();
        chk("R10 queue empty after service", irq_pending, 1'b0);
    endtask

    task automatic t_special();
        irq_en = 1'b0;
        send(3'd7, 8'h20, 1'b0);
        chk("R5 extint masked", irq_pending, 1'b0);
        send(3'd5, 8'h31, 1'b0);
        pres("R4 init while disabled", 1'b1, 3'd3, 8'h31);
        send(3'd4, 8'h22, 1'b0);
        pres("R7 nmi over init", 1'b1, 3'd2, 8'h22);
        send(3'd2, 8'h11, 1'b0);
        pres("R7 smi over nmi", 1'b1, 3'd1, 8'h11);
        send(3'd4, 8'h99, 1'b0);
        do_ack();
        pres("R2 R8 R9 nmi kept after smi ack", 1'b1, 3'd2, 8'h22);
        do_ack();
        pres("R8 R9 init remains", 1'b1, 3'd3, 8'h31);
        do_ack();
        chk("R9 all unmaskable gone", irq_pending, 1'b0);
        irq_en = 1'b1; #1;
        pres("R5 extint when enabled", 1'b1, 3'd4, 8'h20);
        send(3'd0, 8'h90, 1'b0);
        pres("R7 extint over queued", 1'b1, 3'd4, 8'h20);
        do_ack();
        pres("R8 queued after extint ack", 1'b1, 3'd5, 8'h90);
        do_ack();
        do_eoi();
        chk("R11 clean after eoi", irq_pending, 1'b0);
    endtask

    task automatic t_reserved();
        send(3'd3, 8'h55, 1'b0);
        send(3'd6, 8'h66, 1'b1);
        pres("R3 reserved modes ignored", 1'b0, 3'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_queue();
        t_gate();
        t_service();
        t_special();
        t_reserved();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule